// File: doc/BRIEF.md
# Exact Double-Precision Significand Multiplier

This block forms the exact product of two IEEE-754 double-precision operands for an exact-arithmetic accumulation datapath. It separates each operand into sign, biased exponent and fraction. It restores the implicit leading one, multiplies the two 53-bit significands, and keeps the full 106-bit result with no rounding and no renormalization. The accumulator downstream can then add products without losing a single bit.

The multiply is spread over a fixed 14-stage pipeline with no stall path, so one operand pair can enter on every clock. A valid flag travels with each pair. The result sign and the widened, signed exponent are delayed to line up with the significand product. Operands are trusted to be finite and normal. The only special encoding the block recognises is zero.

Top module: `exact_dp_mul`

## Requirements
- R1: For an operand whose bits 62:0 are not all zero, the significand is the 52-bit fraction (bits 51:0) with a leading one placed above it at bit 52. For example, 1.0 times 1.0 gives `out_sig` equal to 2^104.
- R2: `out_sig` is the exact, untruncated 106-bit product of the two 53-bit significands, so any non-zero result has bit 105 or bit 104 set.
- R3: `out_sign` is the XOR of the two operands' bit 63.
- R4: A pair presented with `in_valid` high on a rising edge appears on the outputs, with `out_valid` high, after exactly 14 rising edges. `out_valid` repeats the `in_valid` pattern delayed by 14 cycles.
- R5: `out_exp` is a 13-bit two's-complement value equal to exp_a + exp_b - 1023, where exp_x is bits 62:52 of the operand. Results from -1023 up to 3069 are kept exactly.
- R6: An operand with bits 62:0 all zero (either sign) yields an all-zero `out_sig`. The sign and exponent are still formed as in R3 and R5.
- R7: A new pair is accepted on every clock, and back-to-back inputs give back-to-back results in the same order.
- R8: A synchronous active-high `rst` clears every in-flight valid flag, so `out_valid` is low on the cycle after the reset edge and stays low until pairs that entered after reset come out.
- R9: There is no special-value detection. An exponent field of 2047 is treated as an ordinary number, so 0x7FF0000000000000 times 1.0 gives exponent 2047 and significand 2^104.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand pair on `op_a`/`op_b` is valid this cycle |
| op_a | input | 64 | First double-precision operand |
| op_b | input | 64 | Second double-precision operand |
| out_valid | output | 1 | Result on the outputs is valid |
| out_sign | output | 1 | Sign of the product |
| out_exp | output | 13 | Signed, biased exponent sum of the product |
| out_sig | output | 106 | Exact significand product |

## Verification
A partial sum that is lost or placed in the wrong slice in any accumulation stage shows up as a wrong `out_sig` exactly 14 cycles after the affected pair enters. It often also breaks the rule that a non-zero result occupies bit 105 or bit 104. A delay line that is one stage too short or too long in the sideband shows at once as a misaligned `out_valid` pattern, or as a sign and exponent that belong to the neighbouring pair in a back-to-back stream. Streams with gaps in `in_valid` and a reset in the middle of a full pipeline expose valid flags that survive or are lost.

// File: rtl/exmul_pkg.sv
package exmul_pkg;

  localparam int FP_W    = 64;
  localparam int FRAC_W  = 52;
  localparam int EFLD_W  = 11;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int EXP_W   = EFLD_W + 2;
  localparam int BIAS    = (1 << (EFLD_W - 1)) - 1;

  typedef struct packed {
    logic              sign;
    logic [EFLD_W-1:0] expf;
    logic [SIG_W-1:0]  sig;
    logic              is_zero;
  } fp_parts_t;

  // Split a double into fields; restore the leading one unless the value is zero.
  function automatic fp_parts_t split_fp(input logic [FP_W-1:0] x);
    fp_parts_t p;
    p.sign    = x[FP_W-1];
    p.expf    = x[FP_W-2 -: EFLD_W];
    p.is_zero = (x[FP_W-2:0] == '0);
    p.sig     = {~p.is_zero, x[FRAC_W-1:0]};
    return p;
  endfunction

  // Biased exponent of the product, kept signed and widened so it never wraps.
  function automatic logic signed [EXP_W-1:0] join_exp(input logic [EFLD_W-1:0] ea,
                                                        input logic [EFLD_W-1:0] eb);
    return $signed(EXP_W'(ea)) + $signed(EXP_W'(eb)) - $signed(EXP_W'(BIAS));
  endfunction

endpackage

// File: rtl/exmul_delay.sv
module exmul_delay #(
  parameter int W       = 1,
  parameter int DEPTH   = 14,
  parameter bit CLEARED = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] tap [DEPTH];

  generate
    if (CLEARED) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
        end else begin
          tap[0] <= d;
          for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
      end
    end else begin : g_plain
      logic unused_rst;
      assign unused_rst = rst;
      always_ff @(posedge clk) begin
        tap[0] <= d;
        for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
      end
    end
  endgenerate

  assign q = tap[DEPTH-1];

endmodule

// File: rtl/exmul_sig_pipe.sv
module exmul_sig_pipe #(
  parameter int SIG_W = 53,
  parameter int SLICE = 18,
  parameter int DEPTH = 14
) (
  input  logic               clk,
  input  logic [SIG_W-1:0]   sig_a,
  input  logic [SIG_W-1:0]   sig_b,
  output logic [2*SIG_W-1:0] prod
);

  localparam int NSL    = (SIG_W + SLICE - 1) / SLICE;
  localparam int PAD_W  = NSL * SLICE;
  localparam int NPP    = NSL * NSL;
  localparam int PP_W   = 2 * SLICE;
  localparam int PROD_W = 2 * SIG_W;
  localparam int WIDE_W = 2 * PAD_W;
  localparam int ACC_ST = DEPTH - 2;

  // Weight a slice product by its position; the true total always fits PROD_W.
  function automatic logic [PROD_W-1:0] place_pp(input logic [PP_W-1:0] pp, input int pos);
    logic [WIDE_W-1:0] w;
    w = WIDE_W'(pp) << (pos * SLICE);
    return w[PROD_W-1:0];
  endfunction

  logic [PAD_W-1:0]  ra, rb;
  logic [PP_W-1:0]   pp_q  [1:DEPTH-2][NPP];
  logic [PROD_W-1:0] acc_q [1:DEPTH-1];

  // stage 0: capture padded significands
  always_ff @(posedge clk) begin
    ra <= PAD_W'(sig_a);
    rb <= PAD_W'(sig_b);
  end

  // stage 1: every slice-by-slice product
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSL; i++)
      for (int j = 0; j < NSL; j++)
        pp_q[1][i*NSL+j] <= ra[i*SLICE +: SLICE] * rb[j*SLICE +: SLICE];
    acc_q[1] <= '0;
  end

  // stages 2..DEPTH-1: fold partial products in round-robin order
  generate
    for (genvar s = 2; s < DEPTH; s++) begin : g_acc
      logic [PROD_W-1:0] nxt;
      always_comb begin
        nxt = acc_q[s-1];
        for (int k = 0; k < NPP; k++)
          if (k % ACC_ST == s - 2)
            nxt = nxt + place_pp(pp_q[s-1][k], k / NSL + k % NSL);
      end
      always_ff @(posedge clk) acc_q[s] <= nxt;
      if (s < DEPTH - 1) begin : g_carry
        always_ff @(posedge clk)
          for (int k = 0; k < NPP; k++) pp_q[s][k] <= pp_q[s-1][k];
      end
    end
  endgenerate

  assign prod = acc_q[DEPTH-1];

endmodule

// File: rtl/exact_dp_mul.sv
module exact_dp_mul
  import exmul_pkg::*;
#(
  parameter int SLICE = 18,
  parameter int DEPTH = 14
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [63:0]              op_a,
  input  logic [63:0]              op_b,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic signed [12:0]       out_exp,
  output logic [105:0]             out_sig
);

  fp_parts_t pa, pb;
  assign pa = split_fp(op_a);
  assign pb = split_fp(op_b);

  // named entry-side events for the checker
  logic                    in_sign;
  logic signed [EXP_W-1:0] in_exp;
  logic                    in_zero;
  assign in_sign = pa.sign ^ pb.sign;
  assign in_exp  = join_exp(pa.expf, pb.expf);
  assign in_zero = pa.is_zero | pb.is_zero;

  logic [EXP_W:0] side_q;

  exmul_sig_pipe #(.SIG_W(SIG_W), .SLICE(SLICE), .DEPTH(DEPTH)) u_sig (
    .clk  (clk),
    .sig_a(pa.sig),
    .sig_b(pb.sig),
    .prod (out_sig)
  );

  exmul_delay #(.W(EXP_W + 1), .DEPTH(DEPTH), .CLEARED(1'b0)) u_side (
    .clk(clk),
    .rst(rst),
    .d  ({in_sign, in_exp}),
    .q  (side_q)
  );

  exmul_delay #(.W(1), .DEPTH(DEPTH), .CLEARED(1'b1)) u_vld (
    .clk(clk),
    .rst(rst),
    .d  (in_valid),
    .q  (out_valid)
  );

  assign out_sign = side_q[EXP_W];
  assign out_exp  = $signed(side_q[EXP_W-1:0]);

endmodule

// File: rtl/exact_dp_mul_chk.sv
module exact_dp_mul_chk (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_sign,
  input logic signed [12:0] in_exp,
  input logic               in_zero,
  input logic               out_valid,
  input logic               out_sign,
  input logic signed [12:0] out_exp,
  input logic [105:0]       out_sig
);

  // cycles since reset, saturating, so history lookups stay inside that window
  logic [4:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 5'd31) since_rst <= since_rst + 5'd1;
  end

  assert_valid_delay_R4: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 5'd14) |-> (out_valid == $past(in_valid, 14)));

  assert_sign_align_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 5'd14 && out_valid) |-> (out_sign == $past(in_sign, 14)));

  assert_exp_align_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 5'd14 && out_valid) |-> (out_exp == $past(in_exp, 14)));

  assert_zero_product_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 5'd14 && out_valid && $past(in_zero, 14)) |-> (out_sig == '0));

  assert_top_band_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sig != '0) |-> (out_sig[105:104] != 2'b00));

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

bind exact_dp_mul exact_dp_mul_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_sign  (in_sign),
  .in_exp   (in_exp),
  .in_zero  (in_zero),
  .out_valid(out_valid),
  .out_sign (out_sign),
  .out_exp  (out_exp),
  .out_sig  (out_sig)
);

// File: tb/tb_exact_dp_mul.sv
module tb_exact_dp_mul;

  logic               clk = 1'b0;
  logic               rst;
  logic               in_valid;
  logic [63:0]        op_a, op_b;
  logic               out_valid;
  logic               out_sign;
  logic signed [12:0] out_exp;
  logic [105:0]       out_sig;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  exact_dp_mul dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
  );

  localparam int NV = 11;
  localparam logic [63:0] VA [NV] = '{
    64'h3FF0000000000000, 64'h4000000000000000, 64'h7FEFFFFFFFFFFFFF,
    64'h0010000000000000, 64'h0000000000000000, 64'h8000000000000000,
    64'h400921FB54442D18, 64'h7FEFFFFFFFFFFFFF, 64'hBFF8000000000000,
    64'h3FB999999999999A, 64'h7FF0000000000000};
  localparam logic [63:0] VB [NV] = '{
    64'h3FF0000000000000, 64'hBFF8000000000000, 64'h7FEFFFFFFFFFFFFF,
    64'h0010000000000000, 64'h4008000000000000, 64'h8000000000000000,
    64'h3FB999999999999A, 64'h8010000000000000, 64'h4008000000000000,
    64'h3FB999999999999A, 64'h3FF0000000000000};
  localparam bit VSGN [NV] = '{0, 1, 0, 0, 0, 0, 0, 1, 1, 0, 0};
  localparam int VEXP [NV] = '{1023, 1024, 3069, -1021, 1, -1023, 1020, 1024, 1024, 1015, 2047};

  // reference product by bit-serial shift-and-add
  function automatic logic [105:0] ref_prod(input logic [63:0] a, input logic [63:0] b);
    logic [52:0]  sa, sb;
    logic [105:0] acc;
    sa  = (a[62:0] == 0) ? 53'd0 : {1'b1, a[51:0]};
    sb  = (b[62:0] == 0) ? 53'd0 : {1'b1, b[51:0]};
    acc = '0;
    for (int i = 0; i < 53; i++)
      if (sb[i]) acc = acc + ({53'd0, sa} << i);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R8 reset state", 128'(out_valid), 128'd0);
    rst = 1'b0;

    // table walk: back-to-back stream, results 14 cycles later
    for (int t = 0; t < NV + 14; t++) begin
      @(negedge clk);
      if (t >= 14) begin
        int v;
        v = t - 14;
        check(out_valid == 1'b1, "R7 back-to-back valid", 128'(out_valid), 128'd1);
        check(out_sign == VSGN[v], "R3 sign", 128'(out_sign), 128'(VSGN[v]));
        check(int'(out_exp) == VEXP[v], "R5/R9 exponent", 128'(int'(out_exp)), 128'(VEXP[v]));
        check(out_sig == ref_prod(VA[v], VB[v]), "R2/R6 product", 128'(out_sig), 128'(ref_prod(VA[v], VB[v])));
      end else begin
        check(out_valid == 1'b0, "R4 no early result", 128'(out_valid), 128'd0);
      end
      if (t < NV) begin
        in_valid = 1'b1; op_a = VA[t]; op_b = VB[t];
      end else begin
        in_valid = 1'b0;
      end
    end

    // R1 / R9 directed: exact power-of-two results
    begin
      logic [105:0] one104;
      one104 = 106'd1 << 104;
      check(ref_prod(VA[0], VB[0]) == one104, "R1 reference sanity", 128'(ref_prod(VA[0], VB[0])), 128'(one104));
      @(negedge clk);
      in_valid = 1'b1; op_a = 64'h3FF0000000000000; op_b = 64'h3FF0000000000000;
      @(negedge clk);
      in_valid = 1'b1; op_a = 64'h7FF0000000000000; op_b = 64'h3FF0000000000000;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (12) @(negedge clk);
      check(out_valid && out_sig == one104, "R1 hidden bit 1.0*1.0", 128'(out_sig), 128'(one104));
      @(negedge clk);
      check(out_valid && out_sig == one104 && out_exp == 13'sd2047, "R9 exponent 2047 ordinary",
            128'(out_exp), 128'd2047);
      @(negedge clk);
      check(out_valid == 1'b0, "R4 stream end", 128'(out_valid), 128'd0);
    end

    // R4: valid pattern with gaps, delayed by 14
    begin
      logic [15:0] pat;
      pat = 16'b1011_0010_1110_0101;
      for (int t = 0; t < 16 + 14; t++) begin
        @(negedge clk);
        if (t >= 14) begin
          check(out_valid == pat[t-14], "R4 valid pattern", 128'(out_valid), 128'(pat[t-14]));
          if (pat[t-14])
            check(out_sign == 1'b1 && out_exp == 13'sd1024, "R3/R5 gapped stream", 128'(out_exp), 128'd1024);
        end
        if (t < 16) begin
          in_valid = pat[t]; op_a = VA[8]; op_b = VB[8];
        end else begin
          in_valid = 1'b0;
        end
      end
    end

    // R8: reset in the middle of a full pipeline
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      in_valid = 1'b1; op_a = VA[6]; op_b = VB[6];
    end
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    for (int t = 0; t < 15; t++) begin
      check(out_valid == 1'b0, "R8 flush after reset", 128'(out_valid), 128'd0);
      @(negedge clk);
    end

    finish_run();
  end

endmodule